// File: doc/BRIEF.md
# Bus-Master Disk DMA Engine

This block moves sector data between a disk device and system memory without processor involvement. Software places a table of 8-byte descriptors in memory, writes the table's address into a pointer register, programs the transfer direction and sets a start bit. The engine then fetches each descriptor, streams 16-bit words between the device and the described memory region, and moves on to the next descriptor until one is marked as the last.

When the engine stops, its status byte records how the table length compared with the amount of data the device moved. An exact match gives an interrupt with the engine idle. A table that runs out early gives neither flag. A table with space left over gives the interrupt while the engine still reads as active. Software can halt a transfer at any time by clearing the start bit. A memory fault ends the transfer with an error flag.

Top module: `ide_busmaster_dma`

## Requirements
- R1: After reset, the command, status and pointer registers read 0, no memory request is issued and the interrupt output is low.
- R2: Register offsets are command 0x0 (bit 0 start, bit 3 direction), status 0x2 (bit 0 ACTIVE, bit 1 ERROR, bit 2 INTR) and table pointer 0x4. The pointer is 32 bits and always reads with its two low bits cleared.
- R3: A command write that changes start from 0 to 1 sets ACTIVE and copies the pointer into the fetch address. The engine then reads a descriptor's address word at the fetch address and its count word at fetch address + 4, and advances the fetch address by 8. Bit 31 of the count word marks the last descriptor.
- R4: With direction 1, each device word is written to memory in the low 16 bits of a write request. With direction 0, memory is read and the low 16 bits of the response go to the device. Addresses ascend in steps of 2 from the descriptor address, with its bit 0 ignored.
- R5: A descriptor's byte count is taken from bits 15:0 with bit 0 ignored, and a count of 0 means 65536 bytes.
- R6: When the last descriptor is used up in the cycle the device reports done, status ends as INTR only (0x4).
- R7: When the last descriptor is used up and the device has not reported done, status ends as 0.
- R8: When the device reports done while descriptor space remains, the engine stops requesting memory and status ends as ACTIVE and INTR (0x5).
- R9: A command write with start 0 clears ACTIVE, suppresses any memory request in the same cycle and halts the engine. It takes priority over a completion in the same cycle and leaves INTR as it was.
- R10: Writing 1 to status bit 2 or bit 1 clears INTR or ERROR. A completion or fault that sets the flag in the same cycle wins.
- R11: A memory response flagged as an error sets ERROR and INTR and clears ACTIVE (status 0x6).
- R12: The interrupt output equals INTR and the active output equals ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts and answers the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_err | input | 1 | Memory response is an error, valid with mem_ready |
| dev_rvalid | input | 1 | Device offers a word for memory |
| dev_rdata | input | 16 | Word from the device |
| dev_rready | output | 1 | Device word taken |
| dev_wvalid | output | 1 | Word for the device is valid |
| dev_wdata | output | 16 | Word to the device |
| dev_wready | input | 1 | Device can take a word |
| dev_done | input | 1 | Device has moved all of its data (level) |
| dma_active | output | 1 | ACTIVE status flag |
| dma_irq | output | 1 | INTR status flag |

## Verification
Two pairs of events can share a cycle. A status write can clear INTR in the cycle the device completion sets it. A stop write can arrive in the cycle the engine would evaluate the device's done. The bench provokes each one by issuing the register write in the same cycle that the device raises done. It judges the result with its cycle-level model: INTR survives the clear, and the stop leaves status at 0 with no interrupt.

// File: rtl/ide_busmaster_dma.sv
module ide_busmaster_dma (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  input  logic        dev_rvalid,
  input  logic [15:0] dev_rdata,
  output logic        dev_rready,
  output logic        dev_wvalid,
  output logic [15:0] dev_wdata,
  input  logic        dev_wready,
  input  logic        dev_done,
  output logic        dma_active,
  output logic        dma_irq
);
  localparam logic [2:0] OFS_CMD = 3'd0;
  localparam logic [2:0] OFS_STS = 3'd2;
  localparam logic [2:0] OFS_PTR = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_FADDR, S_FCNT, S_XFER} st_t;
  st_t st;

  logic        run, to_mem, act, err, intr, last;
  logic [31:0] ptr, fptr, cur;
  logic [16:0] left;

  wire wr_cmd   = reg_wr && reg_addr == OFS_CMD;
  wire wr_sts   = reg_wr && reg_addr == OFS_STS;
  wire wr_ptr   = reg_wr && reg_addr == OFS_PTR;
  wire stop_now = wr_cmd && !reg_wdata[0];
  wire go_now   = wr_cmd && reg_wdata[0] && !run;
  wire empty    = left == 17'd0;
  wire in_x     = st == S_XFER && !empty && !dev_done;
  wire fetch    = st == S_FADDR || st == S_FCNT;

  assign mem_req   = !stop_now && (fetch || (in_x && (to_mem ? dev_rvalid : dev_wready)));
  assign mem_we    = st == S_XFER && to_mem;
  assign mem_addr  = st == S_FADDR ? fptr : st == S_FCNT ? fptr + 32'd4 : cur;
  assign mem_wdata = {16'h0000, dev_rdata};

  wire hs    = mem_req && mem_ready;
  wire moved = hs && !mem_err && st == S_XFER;

  assign dev_rready = moved && to_mem;
  assign dev_wvalid = moved && !to_mem;
  assign dev_wdata  = mem_rdata[15:0];
  assign dma_active = act;
  assign dma_irq    = intr;

  always_comb begin
    case (reg_addr)
      OFS_CMD: reg_rdata = {28'd0, to_mem, 2'b00, run};
      OFS_STS: reg_rdata = {29'd0, intr, err, act};
      OFS_PTR: reg_rdata = ptr;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      run <= 1'b0;
      to_mem <= 1'b0;
      act <= 1'b0;
      err <= 1'b0;
      intr <= 1'b0;
      last <= 1'b0;
      ptr <= 32'd0;
      fptr <= 32'd0;
      cur <= 32'd0;
      left <= 17'd0;
    end else begin
      if (wr_cmd) begin
        run <= reg_wdata[0];
        to_mem <= reg_wdata[3];
      end
      if (wr_ptr) ptr <= {reg_wdata[31:2], 2'b00};
      if (wr_sts) begin
        if (reg_wdata[2]) intr <= 1'b0;
        if (reg_wdata[1]) err <= 1'b0;
      end
      if (stop_now) begin
        st <= S_IDLE;
        act <= 1'b0;
      end else if (go_now) begin
        st <= S_FADDR;
        act <= 1'b1;
        fptr <= ptr;
      end else if (hs && mem_err) begin
        st <= S_IDLE;
        act <= 1'b0;
        err <= 1'b1;
        intr <= 1'b1;
      end else begin
        case (st)
          S_FADDR: if (hs) begin
            cur <= {mem_rdata[31:1], 1'b0};
            st <= S_FCNT;
          end
          S_FCNT: if (hs) begin
            left <= {mem_rdata[15:1] == 15'd0, mem_rdata[15:1], 1'b0};
            last <= mem_rdata[31];
            fptr <= fptr + 32'd8;
            st <= S_XFER;
          end
          S_XFER: begin
            if (empty) begin
              if (last) begin
                st <= S_IDLE;
                act <= 1'b0;
                if (dev_done) intr <= 1'b1;
              end else begin
                st <= S_FADDR;
              end
            end else if (dev_done) begin
              st <= S_IDLE;
              intr <= 1'b1;
            end else if (moved) begin
              cur <= cur + 32'd2;
              left <= left - 17'd2;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module ide_busmaster_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ready,
  input logic        mem_err,
  input logic        dev_rready,
  input logic        dev_wvalid,
  input logic        dma_active,
  input logic        dma_irq
);
  // R9
  stop_gates_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !reg_wdata[0]) |-> !mem_req);
  // R9
  stop_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !reg_wdata[0]) |=> !dma_active);
  // R11
  fault_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && mem_err) |=> (dma_irq && !dma_active));
  // R4
  push_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rready |-> (mem_we && mem_ready && !mem_err));
  // R4
  pull_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wvalid |-> (!mem_we && mem_ready && !mem_err));
  // R3
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_active) |-> $past(reg_wr && reg_addr == 3'd0 && reg_wdata[0]));
endmodule

bind ide_busmaster_dma ide_busmaster_dma_chk u_chk (.*);

// File: tb/tb_ide_busmaster_dma.sv
module tb_ide_busmaster_dma;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic mem_req, mem_we, mem_ready, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic dev_rvalid, dev_rready, dev_wvalid, dev_wready, dev_done;
  logic [15:0] dev_rdata, dev_wdata;
  logic dma_active, dma_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ide_busmaster_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata), .dev_rready(dev_rready),
    .dev_wvalid(dev_wvalid), .dev_wdata(dev_wdata), .dev_wready(dev_wready),
    .dev_done(dev_done), .dma_active(dma_active), .dma_irq(dma_irq)
  );

  int runs = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] dmem [0:63];

  bit dev_en = 1'b0, slow = 1'b0, inj = 1'b0, hs_flag = 1'b0;
  int moved = 0, target = 0, cyc = 0;

  int m_st = 0, m_left = 0;
  bit m_run, m_dir, m_act, m_err, m_intr, m_last;
  logic [31:0] m_ptr, m_fptr, m_cur;

  function automatic logic [15:0] pat(logic [31:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  assign mem_rdata = (mem_addr < 32'h100) ? dmem[mem_addr[7:2]] : {16'hC0DE, pat(mem_addr)};

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic bit e_stop();
    return reg_wr && reg_addr == 3'd0 && !reg_wdata[0];
  endfunction

  function automatic bit e_req();
    bit x;
    x = m_st == 3 && m_left != 0 && !dev_done;
    return !e_stop() && (m_st == 1 || m_st == 2 || (x && (m_dir ? dev_rvalid : dev_wready)));
  endfunction

  function automatic logic [31:0] e_addr();
    return m_st == 1 ? m_fptr : m_st == 2 ? m_fptr + 32'd4 : m_cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0; m_run = 0; m_dir = 0; m_act = 0; m_err = 0;
      m_intr = 0; m_last = 0; m_ptr = 0; m_fptr = 0; m_cur = 0;
    end else begin
      bit stop, go, hs, fault;
      logic [31:0] c;
      stop = e_stop();
      go = reg_wr && reg_addr == 3'd0 && reg_wdata[0] && !m_run;
      hs = e_req() && mem_ready;
      fault = hs && mem_err;
      if (reg_wr && reg_addr == 3'd0) begin m_run = reg_wdata[0]; m_dir = reg_wdata[3]; end
      if (reg_wr && reg_addr == 3'd4) m_ptr = reg_wdata & 32'hFFFF_FFFC;
      if (reg_wr && reg_addr == 3'd2) begin
        if (reg_wdata[2]) m_intr = 0;
        if (reg_wdata[1]) m_err = 0;
      end
      if (stop) begin m_st = 0; m_act = 0; end
      else if (go) begin m_st = 1; m_act = 1; m_fptr = m_ptr; end
      else if (fault) begin m_st = 0; m_act = 0; m_err = 1; m_intr = 1; end
      else if (m_st == 1) begin
        if (hs) begin m_cur = dmem[m_fptr[7:2]] & 32'hFFFF_FFFE; m_st = 2; end
      end else if (m_st == 2) begin
        if (hs) begin
          c = dmem[m_fptr[7:2] + 6'd1];
          m_left = ((c[15:0] & 16'hFFFE) == 16'h0) ? 65536 : int'(c[15:0] & 16'hFFFE);
          m_last = c[31];
          m_fptr = m_fptr + 32'd8;
          m_st = 3;
        end
      end else if (m_st == 3) begin
        if (m_left == 0) begin
          if (m_last) begin m_st = 0; m_act = 0; if (dev_done) m_intr = 1; end
          else m_st = 1;
        end else if (dev_done) begin m_st = 0; m_intr = 1; end
        else if (hs) begin m_cur = m_cur + 32'd2; m_left = m_left - 2; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3", {31'd0, mem_req}, {31'd0, e_req()});
      if (mem_req) begin
        check("R3", mem_addr, e_addr());
        check("R4", {31'd0, mem_we}, {31'd0, m_st == 3 && m_dir});
      end
      check("R12", {30'd0, dma_irq, dma_active}, {30'd0, m_intr, m_act});
      if (reg_addr == 3'd2) check("R2", reg_rdata, {29'd0, m_intr, m_err, m_act});
      if (mem_req && mem_ready && mem_we && !mem_err) check("R4", {16'd0, mem_wdata[15:0]}, {16'd0, dev_rdata});
      if (dev_wvalid) check("R4", {16'd0, dev_wdata}, {16'd0, pat(mem_addr)});
      if (dev_rready || dev_wvalid) hs_flag = 1'b1;
    end
  end

  initial begin
    dev_rvalid = 0; dev_wready = 0; dev_done = 0; mem_ready = 0; mem_err = 0; dev_rdata = 0;
    forever begin
      @(posedge clk);
      if (hs_flag) begin moved++; hs_flag = 1'b0; end
      cyc++;
      #1;
      dev_done = dev_en && moved >= target;
      dev_rvalid = dev_en && !dev_done && (slow ? (cyc % 2 == 0) : 1'b1);
      dev_wready = dev_en && !dev_done && (slow ? (cyc % 2 == 0) : 1'b1);
      mem_ready = slow ? (cyc % 3 != 0) : 1'b1;
      mem_err = inj && moved >= 2;
      dev_rdata = 16'h1000 + moved[15:0];
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 3'd2;
  endtask

  task automatic rd(logic [2:0] a, string req, logic [31:0] exp);
    @(posedge clk); #2;
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
    reg_addr = 3'd2;
  endtask

  task automatic prep(logic [31:0] p, int tgt, bit s);
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd6);
    dev_en = 1'b0; inj = 1'b0;
    repeat (2) @(posedge clk);
    #1 moved = 0; target = tgt; slow = s;
    wr(3'd4, p);
  endtask

  task automatic go(bit to_mem);
    dev_en = 1'b1;
    wr(3'd0, to_mem ? 32'd9 : 32'd1);
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (m_st != 0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    reg_wr = 0; reg_addr = 3'd2; reg_wdata = 0;
    for (int i = 0; i < 64; i++) dmem[i] = 32'd0;
    dmem[8] = 32'h1000; dmem[9] = 32'h8;
    dmem[10] = 32'h2001; dmem[11] = 32'h8000_0007;
    dmem[16] = 32'h3000; dmem[17] = 32'h8000_0008;
    dmem[24] = 32'h4000; dmem[25] = 32'h8000_0004;
    dmem[32] = 32'h5000; dmem[33] = 32'h8000_0040;
    dmem[40] = 32'h10000; dmem[41] = 32'h8000_0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, "R1", 32'd0);
    rd(3'd2, "R1", 32'd0);
    rd(3'd4, "R1", 32'd0);
    check("R1", {30'd0, dma_irq, mem_req}, 32'd0);

    // R2 register layout
    wr(3'd4, 32'h123);
    rd(3'd4, "R2", 32'h120);
    wr(3'd0, 32'h8);
    rd(3'd0, "R2", 32'h8);

    // R6 R5 two descriptors, odd count, device to memory, stalls
    prep(32'h20, 7, 1'b1);
    go(1'b1);
    rd(3'd2, "R3", 32'h1);
    wait_idle();
    rd(3'd2, "R6", 32'h4);
    check("R5", moved, 7);
    check("R12", {31'd0, dma_irq}, 32'd1);
    wr(3'd2, 32'h4);
    rd(3'd2, "R10", 32'h0);

    // R4 memory to device, exact end
    prep(32'h40, 4, 1'b0);
    go(1'b0);
    wait_idle();
    rd(3'd2, "R6", 32'h4);
    check("R4", moved, 4);

    // R7 short table
    prep(32'h60, 10, 1'b0);
    go(1'b1);
    wait_idle();
    rd(3'd2, "R7", 32'h0);
    check("R7", moved, 2);

    // R8 long table, then stop
    prep(32'h80, 4, 1'b1);
    go(1'b1);
    wait_idle();
    rd(3'd2, "R8", 32'h5);
    check("R8", {31'd0, mem_req}, 32'd0);
    check("R8", moved, 4);
    wr(3'd0, 32'h8);
    rd(3'd2, "R9", 32'h4);

    // R9 stop in mid-transfer
    prep(32'h80, 100, 1'b1);
    go(1'b1);
    repeat (8) @(posedge clk);
    wr(3'd0, 32'h8);
    rd(3'd2, "R9", 32'h0);
    begin
      int m1;
      m1 = moved;
      repeat (10) @(posedge clk);
      check("R9", moved, m1);
      check("R9", {31'd0, mem_req}, 32'd0);
    end

    // R11 memory fault
    prep(32'h80, 20, 1'b0);
    inj = 1'b1;
    go(1'b0);
    wait_idle();
    rd(3'd2, "R11", 32'h6);
    check("R11", moved, 2);
    inj = 1'b0;
    wr(3'd2, 32'h6);
    rd(3'd2, "R10", 32'h0);

    // R5 zero count means 65536 bytes
    prep(32'hA0, 32768, 1'b0);
    go(1'b1);
    wait_idle();
    rd(3'd2, "R5", 32'h4);
    check("R5", moved, 32768);

    // R10 clear in the completion cycle: set wins
    prep(32'h80, 3, 1'b0);
    go(1'b1);
    wait (dev_done == 1'b1);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h4;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 3'd2;
    rd(3'd2, "R10", 32'h5);

    // R9 stop in the completion cycle: stop wins
    prep(32'h80, 3, 1'b0);
    go(1'b1);
    wait (dev_done == 1'b1);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h8;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 3'd2;
    rd(3'd2, "R9", 32'h0);

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      runs++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", 190000);
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule